// File: doc/BRIEF.md
# Pipeline operand forwarding unit

This block decides, for an in-order pipeline with fetch, decode, execute, memory and write-back stages, where each of the two ALU operands of the instruction now in execute should come from. An operand can come from the register file value read in decode, from the result held in the execute/memory stage register, or from the result held in the memory/write-back stage register. Only a producer that really writes a register, and writes one other than the hardwired zero register, can supply an operand. When both later stages hold a matching result, the newer one wins.

A value being loaded from memory is not ready in time for the next instruction. The block therefore also watches the instruction in decode. If it reads the destination of a load now in execute, the block raises a one-cycle interlock. During that cycle the program counter and the fetch/decode register hold their values, and the control word written into the decode/execute register is forced to zero, so that a bubble moves down the pipe. Every output is purely combinational from the present stage register contents. The enclosing pipeline owns all state.

Top module: `fwd_unit`

## Requirements
- R1: Each operand select is 2 bits wide. 2'b00 picks the register file value, 2'b10 picks the execute/memory result and 2'b01 picks the memory/write-back result. 2'b11 never appears, and 2'b00 is given whenever no qualified producer matches.
- R2: When the execute/memory producer has its write enable set, has a nonzero destination, and that destination equals the first source of the execute instruction, `fwd_a` is 2'b10. The same holds for the second source and `fwd_b`.
- R3: When only the memory/write-back producer qualifies (write enable set, nonzero destination equal to the source), the select for that operand is 2'b01.
- R4: When both producers qualify for the same source, the select is 2'b10.
- R5: A producer whose write enable is clear has no effect on either select, even if its destination matches.
- R6: A producer whose destination is register 0 never causes a forward, whatever its write enable.
- R7: `stall` is 1 exactly when the execute instruction is a load, its destination is nonzero, and that destination equals either source of the decode instruction.
- R8: While `stall` is 1, `idex_ctrl` is all zeros. Otherwise it equals `id_ctrl` bit for bit.
- R9: `stall` is 0 whenever the execute instruction is not a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs | input | 5 | First source register of the instruction in execute |
| ex_rt | input | 5 | Second source register of the instruction in execute |
| ex_rd | input | 5 | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute reads memory into a register |
| exmem_rd | input | 5 | Destination held in the execute/memory stage register |
| exmem_we | input | 1 | Register write enable held in the execute/memory stage register |
| memwb_rd | input | 5 | Destination held in the memory/write-back stage register |
| memwb_we | input | 1 | Register write enable held in the memory/write-back stage register |
| id_rs | input | 5 | First source register of the instruction in decode |
| id_rt | input | 5 | Second source register of the instruction in decode |
| id_ctrl | input | 9 | Control word decoded for the instruction in decode |
| fwd_a | output | 2 | Select for the first ALU operand multiplexer |
| fwd_b | output | 2 | Select for the second ALU operand multiplexer |
| stall | output | 1 | Hold PC and fetch/decode register for one cycle |
| idex_ctrl | output | 9 | Control word to write into the decode/execute register |

## Verification
The bench sweeps every combination of sources, destinations and write enables over registers 0 to 3. This covers the double match on one source, the match whose producer does not write, and the match on register 0. A design with the priority reversed would pick 2'b01 where both stages match. One that skipped the enable or zero qualification would forward stale or constant-zero data. The interlock sweep covers loads and non-loads whose destination hits the first source, the second source, both sources or neither. It also covers a load that targets register 0. A wrong interlock would either stall needlessly or let a dependent instruction read a value that is not there yet. It would also leave the control word live in a bubble.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // register index width for the whole unit
  parameter int unsigned REG_AW = 5;
  // width of the control word carried from decode into execute
  parameter int unsigned CTRL_W = 9;
  // number of ALU operands served
  parameter int unsigned N_OPND = 2;

  localparam int unsigned SEL_W = 2;

  typedef logic [REG_AW-1:0] reg_idx_t;
  typedef logic [SEL_W-1:0]  opnd_sel_t;

  localparam opnd_sel_t SEL_REGFILE = 2'b00;
  localparam opnd_sel_t SEL_MEMWB   = 2'b01;
  localparam opnd_sel_t SEL_EXMEM   = 2'b10;

  localparam reg_idx_t ZERO_REG = '0;

  // a producer may feed a consumer source only if it writes a real register
  function automatic logic producer_hits(input logic we, input reg_idx_t dst,
                                         input reg_idx_t src);
    return we && (dst != ZERO_REG) && (dst == src);
  endfunction

  // newer stage has precedence over older stage
  function automatic opnd_sel_t pick_source(input logic hit_new, input logic hit_old);
    if (hit_new)      return SEL_EXMEM;
    else if (hit_old) return SEL_MEMWB;
    else              return SEL_REGFILE;
  endfunction
endpackage

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect
  import fwd_pkg::*;
(
  input  logic     prod_we,
  input  reg_idx_t prod_rd,
  input  reg_idx_t cons_src,
  output logic     hit
);
  assign hit = producer_hits(prod_we, prod_rd, cons_src);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
(
  input  reg_idx_t  src,
  input  reg_idx_t  exmem_rd,
  input  logic      exmem_we,
  input  reg_idx_t  memwb_rd,
  input  logic      memwb_we,
  output logic      hit_exmem,
  output logic      hit_memwb,
  output opnd_sel_t sel
);
  fwd_hit_detect u_hit_new (
    .prod_we (exmem_we),
    .prod_rd (exmem_rd),
    .cons_src(src),
    .hit     (hit_exmem)
  );

  fwd_hit_detect u_hit_old (
    .prod_we (memwb_we),
    .prod_rd (memwb_rd),
    .cons_src(src),
    .hit     (hit_memwb)
  );

  assign sel = pick_source(hit_exmem, hit_memwb);
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
  import fwd_pkg::*;
(
  input  logic     ex_is_load,
  input  reg_idx_t ex_rd,
  input  reg_idx_t id_rs,
  input  reg_idx_t id_rt,
  input  logic [CTRL_W-1:0] id_ctrl,
  output logic     hit_rs,
  output logic     hit_rt,
  output logic     stall,
  output logic [CTRL_W-1:0] idex_ctrl
);
  // a load in execute acts as a producer whose data is not yet available
  fwd_hit_detect u_lu_rs (
    .prod_we (ex_is_load),
    .prod_rd (ex_rd),
    .cons_src(id_rs),
    .hit     (hit_rs)
  );

  fwd_hit_detect u_lu_rt (
    .prod_we (ex_is_load),
    .prod_rd (ex_rd),
    .cons_src(id_rt),
    .hit     (hit_rt)
  );

  assign stall = hit_rs | hit_rt;

  // bubble insertion: squash the control word entering execute
  assign idex_ctrl = stall ? '0 : id_ctrl;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
(
  input  logic [4:0] ex_rs,
  input  logic [4:0] ex_rt,
  input  logic [4:0] ex_rd,
  input  logic       ex_is_load,
  input  logic [4:0] exmem_rd,
  input  logic       exmem_we,
  input  logic [4:0] memwb_rd,
  input  logic       memwb_we,
  input  logic [4:0] id_rs,
  input  logic [4:0] id_rt,
  input  logic [8:0] id_ctrl,
  output logic [1:0] fwd_a,
  output logic [1:0] fwd_b,
  output logic       stall,
  output logic [8:0] idex_ctrl
);
  reg_idx_t  src_vec [N_OPND];
  opnd_sel_t sel_vec [N_OPND];
  logic [N_OPND-1:0] hit_exmem_vec;
  logic [N_OPND-1:0] hit_memwb_vec;
  logic lu_hit_rs, lu_hit_rt;

  assign src_vec[0] = ex_rs;
  assign src_vec[1] = ex_rt;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fwd_operand_sel u_sel (
      .src      (src_vec[g]),
      .exmem_rd (exmem_rd),
      .exmem_we (exmem_we),
      .memwb_rd (memwb_rd),
      .memwb_we (memwb_we),
      .hit_exmem(hit_exmem_vec[g]),
      .hit_memwb(hit_memwb_vec[g]),
      .sel      (sel_vec[g])
    );
  end

  assign fwd_a = sel_vec[0];
  assign fwd_b = sel_vec[1];

  load_use_detect u_lu (
    .ex_is_load(ex_is_load),
    .ex_rd     (ex_rd),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .id_ctrl   (id_ctrl),
    .hit_rs    (lu_hit_rs),
    .hit_rt    (lu_hit_rt),
    .stall     (stall),
    .idex_ctrl (idex_ctrl)
  );
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk (
  input logic [4:0] ex_rs,
  input logic [4:0] ex_rt,
  input logic [4:0] ex_rd,
  input logic       ex_is_load,
  input logic [4:0] exmem_rd,
  input logic       exmem_we,
  input logic [4:0] memwb_rd,
  input logic       memwb_we,
  input logic [4:0] id_rs,
  input logic [4:0] id_rt,
  input logic [8:0] id_ctrl,
  input logic [1:0] fwd_a,
  input logic [1:0] fwd_b,
  input logic       stall,
  input logic [8:0] idex_ctrl,
  input logic [1:0] hit_exmem_vec,
  input logic [1:0] hit_memwb_vec
);
  always_comb begin
    p_sel_legal_r1: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    // R2, R4: a qualified newer producer always wins at the mux
    p_newer_wins_r4: assert (!hit_exmem_vec[0] || fwd_a == 2'b10);
    p_newer_wins_b_r2: assert (!hit_exmem_vec[1] || fwd_b == 2'b10);
    p_older_only_r3: assert (!(hit_memwb_vec[0] && !hit_exmem_vec[0]) || fwd_a == 2'b01);
    p_no_enable_r5: assert (exmem_we || memwb_we || (fwd_a == 2'b00 && fwd_b == 2'b00));
    p_zero_src_r6: assert ((ex_rs != 5'd0 || fwd_a == 2'b00) && (ex_rt != 5'd0 || fwd_b == 2'b00));
    p_stall_cause_r7: assert (!stall || (ex_rd != 5'd0 && (ex_rd == id_rs || ex_rd == id_rt)));
    p_bubble_r8: assert (!stall || idex_ctrl == '0);
    p_pass_r8: assert (stall || idex_ctrl == id_ctrl);
    p_no_load_r9: assert (ex_is_load || !stall);
    p_rd_used_r2: assert (!hit_exmem_vec[0] || exmem_rd == ex_rs);
    p_wb_used_r3: assert (!hit_memwb_vec[1] || memwb_rd == ex_rt);
  end
endmodule

bind fwd_unit fwd_unit_chk u_chk (
  .ex_rs        (ex_rs),
  .ex_rt        (ex_rt),
  .ex_rd        (ex_rd),
  .ex_is_load   (ex_is_load),
  .exmem_rd     (exmem_rd),
  .exmem_we     (exmem_we),
  .memwb_rd     (memwb_rd),
  .memwb_we     (memwb_we),
  .id_rs        (id_rs),
  .id_rt        (id_rt),
  .id_ctrl      (id_ctrl),
  .fwd_a        (fwd_a),
  .fwd_b        (fwd_b),
  .stall        (stall),
  .idex_ctrl    (idex_ctrl),
  .hit_exmem_vec(hit_exmem_vec),
  .hit_memwb_vec(hit_memwb_vec)
);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] ex_rs = '0, ex_rt = '0, ex_rd = '0, exmem_rd = '0, memwb_rd = '0;
  logic [4:0] id_rs = '0, id_rt = '0;
  logic       ex_is_load = 1'b0, exmem_we = 1'b0, memwb_we = 1'b0;
  logic [8:0] id_ctrl = '0;
  logic [1:0] fwd_a, fwd_b;
  logic       stall;
  logic [8:0] idex_ctrl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  fwd_unit u_fwd_unit (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_is_load(ex_is_load),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we), .memwb_rd(memwb_rd), .memwb_we(memwb_we),
    .id_rs(id_rs), .id_rt(id_rt), .id_ctrl(id_ctrl),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .idex_ctrl(idex_ctrl)
  );

  // expected select and the requirement that governs it
  function automatic logic [1:0] exp_sel(input logic [4:0] s, output string tag);
    bit n, o;
    n = exmem_we && exmem_rd == s && s != 0;
    o = memwb_we && memwb_rd == s && s != 0;
    if (n && o)  begin tag = "R4"; return 2'b10; end
    if (n)       begin tag = "R2"; return 2'b10; end
    if (o)       begin tag = "R3"; return 2'b01; end
    if (s == 0 && (exmem_rd == 0 || memwb_rd == 0)) tag = "R6";
    else if (exmem_rd == s || memwb_rd == s)        tag = "R5";
    else                                             tag = "R1";
    return 2'b00;
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    string t;
    logic [1:0] e;
    // reset state: all inputs zero, nothing forwards, no stall (R1, R9)
    @(negedge clk);
    check("R1", {7'd0, fwd_a}, 9'd0);
    check("R9", {8'd0, stall}, 9'd0);
    // forwarding sweep over registers 0..3
    for (int m = 0; m < 1024; m++) begin
      @(posedge clk);
      ex_rs    = 5'(m[1:0]);
      ex_rt    = 5'(m[3:2]);
      exmem_rd = 5'(m[5:4]);
      memwb_rd = 5'(m[7:6]);
      exmem_we = m[8];
      memwb_we = m[9];
      @(negedge clk);
      e = exp_sel(ex_rs, t);
      check({t, " fwd_a"}, {7'd0, fwd_a}, {7'd0, e});
      e = exp_sel(ex_rt, t);
      check({t, " fwd_b"}, {7'd0, fwd_b}, {7'd0, e});
    end
    // interlock sweep; forwarding inputs idle
    for (int m = 0; m < 128; m++) begin
      bit exp_st;
      @(posedge clk);
      ex_rd      = 5'(m[1:0]);
      id_rs      = 5'(m[3:2]);
      id_rt      = 5'(m[5:4]);
      ex_is_load = m[6];
      id_ctrl    = 9'h1A5 ^ 9'(m * 37);
      @(negedge clk);
      exp_st = ex_is_load && ex_rd != 0 && (ex_rd == id_rs || ex_rd == id_rt);
      check(ex_is_load ? "R7 stall" : "R9 stall", {8'd0, stall}, {8'd0, exp_st});
      check("R8 ctrl", idex_ctrl, exp_st ? 9'd0 : id_ctrl);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule